// File: doc/BRIEF.md
# Data-Dependent-Latency Sequential Multiplier

This block multiplies a 16-bit multiplicand by a 16-bit source operand over many clocks and returns a 32-bit product. A mode input selects either unsigned operation or two's-complement operation. Signed mode uses radix-2 Booth recoding of the source operand. The time the block stays busy depends on the source operand's bit pattern. It is 38 clocks plus 2 clocks for every add or subtract event. In unsigned mode an event is a one bit of the source. In signed mode an event is a change between neighbouring bits of the source, after a zero has been placed below its least significant bit.

A caller raises `start` for one clock with the operands and the mode. It then waits for the one-clock `done` pulse and reads `product` and `cycles`. The `cycles` output reports the latency the operation used, so the caller can account for the data-dependent time of each multiply. A request made while an operation is running is dropped.

Top module: `varlat_mul`

## Requirements
- R1: `start` sampled high on a rising edge while `busy` is low accepts an operation; that edge is edge 0. After it, `busy` is 1 and `cycles` is 0.
- R2: With `signed_mode` = 0, `product` equals the unsigned product of `multiplicand` and `source`, e.g. 0xFFFF x 0xFFFF = 0xFFFE0001.
- R3: With `signed_mode` = 1, both operands are read as two's complement and `product` is the 32-bit two's-complement product. This includes -32768 x -32768 = 0x40000000 and -32768 x 32767 = 0xC0008000.
- R4: In unsigned mode the latency L is 38 + 2n, where n is the number of one bits in `source` (0 gives 38, 0xFFFF gives 70).
- R5: In signed mode the latency L is 38 + 2n. Here n is the number of unequal adjacent bit pairs in the 17-bit value {source, 0}. A source of 0x5555 gives n = 16 and L = 70; 0xFFFF gives L = 40.
- R6: `done` is 1 for exactly one clock, the one after edge L. `busy` stays 1 from after edge 0 through that clock, and both are 0 after edge L+1.
- R7: A `start` arriving while `busy` is 1 is ignored. The running operation's product, `cycles` value and done timing are unchanged.
- R8: When `done` is 1, `cycles` equals L. `product` and `cycles` hold their values until the next accepted `start`.
- R9: Synchronous active-high `rst` sets `busy`, `done`, `cycles` and `product` to 0, even in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiply (honoured only when idle) |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's complement |
| multiplicand | input | 16 | Multiplicand operand |
| source | input | 16 | Source operand; its bit pattern sets the latency |
| busy | output | 1 | Operation in progress, through the done clock |
| done | output | 1 | One-clock completion pulse |
| product | output | 32 | Result, valid from done until the next accepted start |
| cycles | output | 7 | Clocks used by the last operation (38 + 2n) |

## Verification
Sources with no ones, all ones, alternating ones and a single one each produce a distinct event count. They separate a correct popcount from the Booth transition count: 0x0005 costs 42 clocks unsigned but 46 signed, and 0xFFFF costs 70 against 40. Signed vectors with -1, -2 and -32768 on either side expose errors in sign extension and in the subtract path. The same 0x8000 x 0x8000 operands in both modes show that the mode changes both the product and the timing. Directed runs then raise `start` during an operation and assert reset mid-operation, to show the running result is not disturbed and that reset clears it.

// File: rtl/mulv_pkg.sv
package mulv_pkg;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mul_mode_e;

    localparam int unsigned MUL_W_DEF      = 16;
    localparam int unsigned BASE_CLKS_DEF  = 38;
    localparam int unsigned EVENT_CLKS_DEF = 2;

    // Worst-case latency for a given width; sizes the cycle counter.
    function automatic int unsigned max_latency(input int unsigned w,
                                                input int unsigned base,
                                                input int unsigned per_ev);
        return base + per_ev * w;
    endfunction

endpackage

// File: rtl/mul_cost.sv
module mul_cost
    import mulv_pkg::*;
#(
    parameter int unsigned W      = MUL_W_DEF,
    parameter int unsigned BASE   = BASE_CLKS_DEF,
    parameter int unsigned PER_EV = EVENT_CLKS_DEF,
    parameter int unsigned CW     = 7
) (
    input  mul_mode_e      mode,
    input  logic [W-1:0]   src,
    output logic [CW-1:0]  latency
);
    localparam int unsigned NW = $clog2(W + 1);

    logic [W:0]   ext;
    logic [W-1:0] ev_bits;
    logic [NW-1:0] ev_cnt;

    assign ext = {src, 1'b0};

    // One event flag per source bit; the mode picks the event rule.
    for (genvar i = 0; i < W; i++) begin : g_event
        assign ev_bits[i] = (mode == MODE_SIGNED) ? (ext[i+1] ^ ext[i]) : src[i];
    end

    always_comb begin
        ev_cnt = '0;
        for (int i = 0; i < W; i++) begin
            ev_cnt = ev_cnt + NW'(ev_bits[i]);
        end
    end

    always_comb begin
        latency = CW'(BASE + PER_EV * 32'(ev_cnt));
    end

endmodule

// File: rtl/mul_engine.sv
module mul_engine
    import mulv_pkg::*;
#(
    parameter int unsigned W = MUL_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  mul_mode_e      mode,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   src,
    output logic [2*W-1:0] product
);
    localparam int unsigned SW = $clog2(W + 1);

    typedef struct packed {
        logic [W:0]   acc;
        logic [W-1:0] q;
        logic         q_1;
    } eng_state_t;

    eng_state_t    st, st_nxt;
    logic [W:0]    m_ext;
    logic          sgn;
    logic [SW-1:0] steps;
    logic [W:0]    sum;
    logic          top_in;

    // One recode-and-shift step of the combined accumulator/multiplier.
    always_comb begin
        sum = st.acc;
        if (sgn) begin
            unique case ({st.q[0], st.q_1})
                2'b01:   sum = st.acc + m_ext;
                2'b10:   sum = st.acc - m_ext;
                default: sum = st.acc;
            endcase
        end else if (st.q[0]) begin
            sum = st.acc + m_ext;
        end
        top_in       = sgn ? sum[W] : 1'b0;
        st_nxt.acc   = {top_in, sum[W:1]};
        st_nxt.q     = {sum[0], st.q[W-1:1]};
        st_nxt.q_1   = st.q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            m_ext <= '0;
            sgn   <= 1'b0;
            steps <= '0;
        end else if (load) begin
            st.acc <= '0;
            st.q   <= src;
            st.q_1 <= 1'b0;
            sgn    <= (mode == MODE_SIGNED);
            m_ext  <= (mode == MODE_SIGNED) ? {mcand[W-1], mcand} : {1'b0, mcand};
            steps  <= SW'(W);
        end else if (steps != '0) begin
            st    <= st_nxt;
            steps <= steps - 1'b1;
        end
    end

    assign product = {st.acc[W-1:0], st.q};

endmodule

// File: rtl/mul_timer.sv
module mul_timer #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [CW-1:0] target,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] elapsed
);
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = elapsed + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            elapsed <= '0;
        end else if (launch) begin
            busy    <= 1'b1;
            done    <= 1'b0;
            elapsed <= '0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                done <= 1'b0;
            end else begin
                elapsed <= cnt_inc;
                done    <= (cnt_inc == target);
            end
        end
    end

endmodule

// File: rtl/varlat_mul.sv
module varlat_mul
    import mulv_pkg::*;
#(
    parameter int unsigned W      = MUL_W_DEF,
    parameter int unsigned BASE   = BASE_CLKS_DEF,
    parameter int unsigned PER_EV = EVENT_CLKS_DEF,
    localparam int unsigned PW    = 2 * W,
    localparam int unsigned CW    = $clog2(max_latency(W, BASE, PER_EV) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          signed_mode,
    input  logic [W-1:0]  multiplicand,
    input  logic [W-1:0]  source,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] product,
    output logic [CW-1:0] cycles
);
    mul_mode_e     mode_in;
    logic          launch;
    logic [CW-1:0] lat_now;
    logic [CW-1:0] lat_q;

    assign mode_in = mul_mode_e'(signed_mode);
    assign launch  = start & ~busy;

    mul_cost #(.W(W), .BASE(BASE), .PER_EV(PER_EV), .CW(CW)) u_cost (
        .mode    (mode_in),
        .src     (source),
        .latency (lat_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (launch) begin
            lat_q <= lat_now;
        end
    end

    mul_engine #(.W(W)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .load    (launch),
        .mode    (mode_in),
        .mcand   (multiplicand),
        .src     (source),
        .product (product)
    );

    mul_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .target  (lat_q),
        .busy    (busy),
        .done    (done),
        .elapsed (cycles)
    );

endmodule

// File: rtl/varlat_mul_chk.sv
module varlat_mul_chk #(
    parameter int unsigned W      = 16,
    parameter int unsigned BASE   = 38,
    parameter int unsigned PER_EV = 2,
    parameter int unsigned CW     = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [2*W-1:0] product,
    input logic [CW-1:0] cycles
);
    // R1: an accepted start raises busy and clears the count
    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cycles == '0));

    // R6: done lasts one clock
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: done only inside busy
    p_done_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R6: busy falls right after done
    p_busy_drop_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R7: a running operation keeps counting; no restart
    p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && 32'(cycles) == 32'($past(cycles)) + 1));

    // R8: reported latency within the legal range
    p_lat_range_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(cycles) >= BASE && 32'(cycles) <= BASE + PER_EV * W));

    // R8: results hold while idle
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(product) && $stable(cycles)));

endmodule

bind varlat_mul varlat_mul_chk #(.W(W), .BASE(BASE), .PER_EV(PER_EV), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product),
    .cycles  (cycles)
);

// File: tb/test_varlat_mul.sv
`timescale 1ns/1ps
module test_varlat_mul;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        signed_mode;
    logic [15:0] multiplicand;
    logic [15:0] source;
    logic        busy;
    logic        done;
    logic [31:0] product;
    logic [6:0]  cycles;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    varlat_mul i_varlat_mul (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .signed_mode  (signed_mode),
        .multiplicand (multiplicand),
        .source       (source),
        .busy         (busy),
        .done         (done),
        .product      (product),
        .cycles       (cycles)
    );

    typedef struct packed {
        logic        sgn;
        logic [15:0] a;
        logic [15:0] b;
        logic [31:0] p;
        logic [6:0]  lat;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h0003, 16'h0005, 32'h0000000F, 7'd42},
        '{1'b0, 16'hFFFF, 16'hFFFF, 32'hFFFE0001, 7'd70},
        '{1'b0, 16'h1234, 16'h0000, 32'h00000000, 7'd38},
        '{1'b1, 16'hFFFF, 16'h5555, 32'hFFFFAAAB, 7'd70},
        '{1'b1, 16'h8000, 16'h8000, 32'h40000000, 7'd40},
        '{1'b1, 16'h0007, 16'hFFFF, 32'hFFFFFFF9, 7'd40},
        '{1'b1, 16'h8000, 16'h7FFF, 32'hC0008000, 7'd42},
        '{1'b0, 16'h8000, 16'h8000, 32'h40000000, 7'd40},
        '{1'b1, 16'h0003, 16'h0005, 32'h0000000F, 7'd46},
        '{1'b0, 16'h00FF, 16'hAAAA, 32'h00A9FF56, 7'd54},
        '{1'b1, 16'hFFFE, 16'hAAAA, 32'h0000AAAC, 7'd68}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Runs one operation; optionally raises start again while busy.
    task automatic run_op(input logic sgn, input logic [15:0] a, input logic [15:0] b,
                          input bit inject, output int unsigned lat,
                          output logic [31:0] p, output logic [6:0] cyc,
                          output bit shape_ok);
        shape_ok = 1'b1;
        lat = 0;
        @(negedge clk);
        start = 1'b1; signed_mode = sgn; multiplicand = a; source = b;
        @(negedge clk);
        start = 1'b0;
        if (!busy || done || cycles != 7'd0) shape_ok = 1'b0;
        for (int k = 1; k < 200; k++) begin
            @(negedge clk);
            if (inject && k == 5) begin
                start = 1'b1; signed_mode = ~sgn; multiplicand = ~a; source = 16'h5555;
            end
            if (inject && k == 6) start = 1'b0;
            if (done) begin
                lat = k;
                if (!busy) shape_ok = 1'b0;
                break;
            end
            if (!busy) begin
                shape_ok = 1'b0;
                break;
            end
        end
        p = product;
        cyc = cycles;
        @(negedge clk);
        if (done || busy) shape_ok = 1'b0;
        if (product != p || cycles != cyc) shape_ok = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unsigned lat;
        logic [31:0] p;
        logic [6:0]  cyc;
        bit          shp;
        string       rq;

        rst = 1'b1; start = 1'b0; signed_mode = 1'b0;
        multiplicand = '0; source = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!busy && !done, "R9", "busy/done after reset", {busy, done}, 0);
        check(product == 32'd0, "R9", "product after reset", product, 0);
        check(cycles == 7'd0, "R9", "cycles after reset", cycles, 0);
        rst = 1'b0;

        // Vector table: R2/R3 products, R4/R5 latencies, R1/R6/R8 shape
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].sgn, VEC[i].a, VEC[i].b, 1'b0, lat, p, cyc, shp);
            rq = VEC[i].sgn ? "R3" : "R2";
            check(p == VEC[i].p, rq, $sformatf("product vec %0d", i), p, VEC[i].p);
            rq = VEC[i].sgn ? "R5" : "R4";
            check(lat == 32'(VEC[i].lat), rq, $sformatf("done latency vec %0d", i), lat, VEC[i].lat);
            check(cyc == VEC[i].lat, "R8", $sformatf("cycles port vec %0d", i), cyc, VEC[i].lat);
            check(shp, "R6", $sformatf("busy/done shape, R1 accept, vec %0d", i), shp, 1);
        end

        // R7: start during busy is ignored
        run_op(1'b0, 16'h0003, 16'h0005, 1'b1, lat, p, cyc, shp);
        check(p == 32'h0000000F, "R7", "product with extra start", p, 32'h0000000F);
        check(lat == 42, "R7", "latency with extra start", lat, 42);
        check(cyc == 7'd42, "R7", "cycles with extra start", cyc, 42);
        check(shp, "R7", "shape with extra start", shp, 1);

        // R8: idle hold over several clocks
        repeat (5) @(negedge clk);
        check(product == 32'h0000000F && cycles == 7'd42, "R8", "idle hold",
              {product, 1'b0, cycles}, {32'h0000000F, 1'b0, 7'd42});

        // R9: reset in the middle of an operation
        @(negedge clk);
        start = 1'b1; signed_mode = 1'b1; multiplicand = 16'h1234; source = 16'h5555;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done, "R9", "busy/done after mid reset", {busy, done}, 0);
        check(product == 32'd0 && cycles == 7'd0, "R9", "outputs after mid reset",
              {product, 1'b0, cycles}, 0);

        // R1: back-to-back operation after reset works
        run_op(1'b1, 16'h8000, 16'h8000, 1'b0, lat, p, cyc, shp);
        check(p == 32'h40000000 && lat == 40 && shp, "R1", "operation after mid reset",
              {p, lat[7:0]}, {32'h40000000, 8'd40});

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule